// File: doc/BRIEF.md
# Parallel block ripple adder

A purely combinational N-bit adder, with N a multiple of four, built from 4-bit ripple slices that do not wait on each other's ripple chains. Each slice above the lowest gets its carry-in from a small lookahead unit. The lookahead unit forms that carry from the per-bit propagate and generate signals of the slice below it and from that slice's own carry-in. As a result the lookahead units form a short chain, and every slice ripples only four bits after its carry arrives.

The parameter Q replaces the top Q slices with carry-select slices. Each of these forms its 4-bit result for a zero carry-in with one ripple adder. It derives the result for a one carry-in with increment logic, and a multiplexer picks between the two when the real carry arrives. Only the lowest carry-select slice is fed by a lookahead unit. Each higher one takes the carry-out of the carry-select slice directly below it. The block has no clock and no reset. It is placed wherever a cheap adder with a shorter critical path than a plain ripple adder is wanted.

Top module: `bra_adder`

## Requirements
- R1: N must be 4k with k ≥ 1, and the adder is built from N/4 slices of four bits each. Q must lie in 0..4 and must not exceed N/4. N = 4 with Q = 1 is a legal single-slice build.
- R2: The carry-in of the lowest slice is the external carry_in.
- R3: For every slice i with 1 ≤ i ≤ N/4−Q, the carry-in comes from a lookahead unit. That carry equals G3 + P3·G2 + P3·P2·G1 + P3·P2·P1·G0 + P3·P2·P1·P0·Cprev over slice i−1, where Pj = a XOR b and Gj = a AND b, and Cprev is the carry-in of slice i−1. It therefore equals the true carry into bit 4i.
- R4: Every carry-select slice above the lowest carry-select slice takes as its carry-in the carry-out of the slice directly below it.
- R5: A carry-select slice outputs the 4-bit sum and the carry that a ripple slice would produce for the same operands and carry-in.
- R6: total equals the low N bits of opa + opb + carry_in for every input combination.
- R7: carry_out equals bit N of opa + opb + carry_in, which is the carry-out of the top slice.
- R8: R6 and R7 hold for every Q from 0 to 4, including all-ripple (Q = 0) and all-select builds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand |
| opb | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| total | output | N | Low N bits of the sum |
| carry_out | output | 1 | Carry out of bit N−1 |

## Verification
The bound checker re-evaluates on every input change and checks the following. The lowest slice's carry-in must equal carry_in. Each lookahead carry must equal the true prefix carry at its slice boundary. Each slice's carry-out must agree with the carry-in of the slice above it, and with carry_out for the top slice. The sum of each carry-select slice and the full result must match an independent addition. Because only one parameter set can be bound per instance, the bench shows R1 and R8 by building several width and Q combinations side by side. It drives long propagate runs across every slice boundary, generate-only patterns and random operands through all of them at once.

// File: rtl/bra_pkg.sv
`timescale 1ns/1ps
package bra_pkg;

  localparam int SLICE_W = 4;

  // Ripple four bits from propagate/generate; result is {carry, sum[3:0]}.
  function automatic logic [SLICE_W:0] ripple_pg(input logic [SLICE_W-1:0] p,
                                                 input logic [SLICE_W-1:0] g,
                                                 input logic c);
    logic [SLICE_W-1:0] s;
    logic cc;
    cc = c;
    for (int j = 0; j < SLICE_W; j++) begin
      s[j] = p[j] ^ cc;
      cc   = g[j] | (p[j] & cc);
    end
    return {cc, s};
  endfunction

  // Two-level lookahead carry over one slice.
  function automatic logic lookahead_carry(input logic [SLICE_W-1:0] p,
                                           input logic [SLICE_W-1:0] g,
                                           input logic c);
    return g[3]
         | (p[3] & g[2])
         | (p[3] & p[2] & g[1])
         | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & c);
  endfunction

  // Derive the carry-in-one result from the carry-in-zero result.
  function automatic logic [SLICE_W:0] plus_one(input logic [SLICE_W:0] r0);
    logic [SLICE_W-1:0] s1;
    logic run;
    run = 1'b1;
    for (int j = 0; j < SLICE_W; j++) begin
      s1[j] = r0[j] ^ run;
      run   = run & r0[j];
    end
    return {r0[SLICE_W] | run, s1};
  endfunction

endpackage

// File: rtl/bra_pg_gen.sv
`timescale 1ns/1ps
module bra_pg_gen
  import bra_pkg::*;
(
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  output logic [SLICE_W-1:0] prop_o,
  output logic [SLICE_W-1:0] gen_o
);
  assign prop_o = a_i ^ b_i;
  assign gen_o  = a_i & b_i;
endmodule

// File: rtl/bra_lookahead.sv
`timescale 1ns/1ps
module bra_lookahead
  import bra_pkg::*;
(
  input  logic [SLICE_W-1:0] prop_i,
  input  logic [SLICE_W-1:0] gen_i,
  input  logic               cprev_i,
  output logic               carry_o
);
  assign carry_o = lookahead_carry(prop_i, gen_i, cprev_i);
endmodule

// File: rtl/bra_ripple_slice.sv
`timescale 1ns/1ps
module bra_ripple_slice
  import bra_pkg::*;
(
  input  logic [SLICE_W-1:0] prop_i,
  input  logic [SLICE_W-1:0] gen_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               cout_o
);
  logic [SLICE_W:0] res_w;
  assign res_w  = ripple_pg(prop_i, gen_i, cin_i);
  assign sum_o  = res_w[SLICE_W-1:0];
  assign cout_o = res_w[SLICE_W];
endmodule

// File: rtl/bra_select_slice.sv
`timescale 1ns/1ps
module bra_select_slice
  import bra_pkg::*;
(
  input  logic [SLICE_W-1:0] prop_i,
  input  logic [SLICE_W-1:0] gen_i,
  input  logic               cin_i,
  output logic [SLICE_W-1:0] sum_o,
  output logic               cout_o
);
  logic [SLICE_W:0] res_zero_w;
  logic [SLICE_W:0] res_one_w;
  logic [SLICE_W:0] chosen_w;

  assign res_zero_w = ripple_pg(prop_i, gen_i, 1'b0);
  assign res_one_w  = plus_one(res_zero_w);
  assign chosen_w   = cin_i ? res_one_w : res_zero_w;
  assign sum_o      = chosen_w[SLICE_W-1:0];
  assign cout_o     = chosen_w[SLICE_W];
endmodule

// File: rtl/bra_adder.sv
`timescale 1ns/1ps
module bra_adder
  import bra_pkg::*;
#(
  parameter int N = 32,
  parameter int Q = 2
)(
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         carry_in,
  output logic [N-1:0] total,
  output logic         carry_out
);
  localparam int SLICES = N / SLICE_W;
  localparam int LOW_CS = SLICES - Q;

  // Observation wires for the checker.
  logic [SLICES-1:0] slice_cin_w;
  logic [SLICES-1:0] slice_cout_w;

  if ((N % SLICE_W) != 0 || N < SLICE_W || Q < 0 || Q > 4 || Q > SLICES) begin : g_bad_params
    $error("bra_adder: illegal N/Q combination");
  end

  for (genvar i = 0; i < SLICES; i++) begin : g_sl
    logic [SLICE_W-1:0] p_s;
    logic [SLICE_W-1:0] g_s;
    logic [SLICE_W-1:0] sum_s;
    logic               cin_s;
    logic               cout_s;

    bra_pg_gen u_pg (
      .a_i    (opa[SLICE_W*i +: SLICE_W]),
      .b_i    (opb[SLICE_W*i +: SLICE_W]),
      .prop_o (p_s),
      .gen_o  (g_s)
    );

    if (i == 0) begin : g_base
      assign cin_s = carry_in;
    end else if (i <= LOW_CS) begin : g_la
      bra_lookahead u_la (
        .prop_i  (g_sl[i-1].p_s),
        .gen_i   (g_sl[i-1].g_s),
        .cprev_i (g_sl[i-1].cin_s),
        .carry_o (cin_s)
      );
    end else begin : g_chain
      assign cin_s = g_sl[i-1].cout_s;
    end

    if (i >= LOW_CS) begin : g_sel
      bra_select_slice u_slice (
        .prop_i (p_s),
        .gen_i  (g_s),
        .cin_i  (cin_s),
        .sum_o  (sum_s),
        .cout_o (cout_s)
      );
    end else begin : g_rip
      bra_ripple_slice u_slice (
        .prop_i (p_s),
        .gen_i  (g_s),
        .cin_i  (cin_s),
        .sum_o  (sum_s),
        .cout_o (cout_s)
      );
    end

    assign total[SLICE_W*i +: SLICE_W] = sum_s;
    assign slice_cin_w[i]  = cin_s;
    assign slice_cout_w[i] = cout_s;
  end

  assign carry_out = g_sl[SLICES-1].cout_s;

endmodule

// File: rtl/bra_adder_chk.sv
`timescale 1ns/1ps
module bra_adder_chk #(
  parameter int N = 32,
  parameter int Q = 2
)(
  input logic [N-1:0]   opa,
  input logic [N-1:0]   opb,
  input logic           carry_in,
  input logic [N-1:0]   total,
  input logic           carry_out,
  input logic [N/4-1:0] slice_cin_w,
  input logic [N/4-1:0] slice_cout_w
);
  localparam int SLICES = N / 4;
  localparam int LOW_CS = SLICES - Q;

  function automatic logic carry_at(input logic [N-1:0] x, input logic [N-1:0] y,
                                    input logic c, input int pos);
    logic [N:0] m;
    logic [N:0] w;
    m = ((N+1)'(1) << pos) - (N+1)'(1);
    w = ({1'b0, x} & m) + ({1'b0, y} & m) + (N+1)'(c);
    return w[pos];
  endfunction

  function automatic logic [N:0] full_sum(input logic [N-1:0] x, input logic [N-1:0] y,
                                          input logic c);
    return {1'b0, x} + {1'b0, y} + (N+1)'(c);
  endfunction

  function automatic logic [3:0] slice_sum(input logic [3:0] x, input logic [3:0] y,
                                           input logic c);
    logic [4:0] w;
    w = {1'b0, x} + {1'b0, y} + 5'(c);
    return w[3:0];
  endfunction

  always_comb begin
    p_base_cin_r2: assert (slice_cin_w[0] == carry_in)
      else $error("R2 lowest slice carry-in differs from carry_in");
    p_sum_exact_r6: assert (total == full_sum(opa, opb, carry_in)[N-1:0])
      else $error("R6 total wrong");
    p_cout_exact_r7: assert (carry_out == full_sum(opa, opb, carry_in)[N])
      else $error("R7 carry_out wrong");
    p_top_cout_r7: assert (slice_cout_w[SLICES-1] == carry_out)
      else $error("R7 top slice carry-out differs from carry_out");
    for (int i = 1; i < SLICES; i++) begin
      if (i <= LOW_CS) begin
        p_lookahead_r3: assert (slice_cin_w[i] == carry_at(opa, opb, carry_in, 4*i))
          else $error("R3 lookahead carry wrong at slice %0d", i);
      end else begin
        p_select_chain_r4: assert (slice_cin_w[i] == slice_cout_w[i-1])
          else $error("R4 select chain broken at slice %0d", i);
      end
      p_slice_agree_r3: assert (slice_cout_w[i-1] == slice_cin_w[i])
        else $error("R3 slice %0d carry-out disagrees with next carry-in", i-1);
    end
    for (int i = 0; i < SLICES; i++) begin
      if (i >= LOW_CS) begin
        p_select_sum_r5: assert (total[4*i +: 4] ==
                                 slice_sum(opa[4*i +: 4], opb[4*i +: 4], slice_cin_w[i]))
          else $error("R5 select slice %0d sum wrong", i);
      end
    end
  end
endmodule

bind bra_adder bra_adder_chk #(.N(N), .Q(Q)) chk_i (
  .opa          (opa),
  .opb          (opb),
  .carry_in     (carry_in),
  .total        (total),
  .carry_out    (carry_out),
  .slice_cin_w  (slice_cin_w),
  .slice_cout_w (slice_cout_w)
);

// File: tb/bra_adder_tb_top.sv
`timescale 1ns/1ps
module bra_adder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] a_r = '0;
  logic [63:0] b_r = '0;
  logic        c_r = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [31:0] s32;  logic co32;
  logic [15:0] s16a; logic co16a;
  logic [15:0] s16b; logic co16b;
  logic [31:0] s32c; logic co32c;
  logic [63:0] s64;  logic co64;
  logic [3:0]  s4;   logic co4;

  bra_adder #(.N(32), .Q(2)) dut_i (.opa(a_r[31:0]), .opb(b_r[31:0]), .carry_in(c_r),
                                    .total(s32), .carry_out(co32));
  bra_adder #(.N(16), .Q(0)) dut_n16q0_i (.opa(a_r[15:0]), .opb(b_r[15:0]), .carry_in(c_r),
                                          .total(s16a), .carry_out(co16a));
  bra_adder #(.N(16), .Q(1)) dut_n16q1_i (.opa(a_r[15:0]), .opb(b_r[15:0]), .carry_in(c_r),
                                          .total(s16b), .carry_out(co16b));
  bra_adder #(.N(32), .Q(3)) dut_n32q3_i (.opa(a_r[31:0]), .opb(b_r[31:0]), .carry_in(c_r),
                                          .total(s32c), .carry_out(co32c));
  bra_adder #(.N(64), .Q(4)) dut_n64q4_i (.opa(a_r), .opb(b_r), .carry_in(c_r),
                                          .total(s64), .carry_out(co64));
  bra_adder #(.N(4), .Q(1))  dut_n4q1_i  (.opa(a_r[3:0]), .opb(b_r[3:0]), .carry_in(c_r),
                                          .total(s4), .carry_out(co4));

  function automatic logic [64:0] ref_sum(input logic [63:0] x, input logic [63:0] y,
                                          input logic c, input int w);
    logic [64:0] m;
    logic [64:0] r;
    m = (65'(1) << w) - 65'(1);
    r = ({1'b0, x} & m) + ({1'b0, y} & m) + 65'(c);
    return r & ((65'(1) << (w + 1)) - 65'(1));
  endfunction

  task automatic cmp(input string tag, input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h c=%b)", tag, got, exp, a_r, b_r, c_r);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " R6/R7 n32q2"}, 65'({co32, s32}),   ref_sum(a_r, b_r, c_r, 32));
    cmp({tag, " R8 n16q0"},    65'({co16a, s16a}), ref_sum(a_r, b_r, c_r, 16));
    cmp({tag, " R8 n16q1"},    65'({co16b, s16b}), ref_sum(a_r, b_r, c_r, 16));
    cmp({tag, " R8 n32q3"},    65'({co32c, s32c}), ref_sum(a_r, b_r, c_r, 32));
    cmp({tag, " R8 n64q4"},    65'({co64, s64}),   ref_sum(a_r, b_r, c_r, 64));
    cmp({tag, " R1 n4q1"},     65'({co4, s4}),     ref_sum(a_r, b_r, c_r, 4));
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic c,
                       input string tag);
    @(negedge clk);
    a_r = x; b_r = y; c_r = c;
    #5;
    check_all(tag);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #5;
    check_all("reset-state R2");
    rst_n = 1'b1;

    apply(64'h0, 64'h0, 1'b1, "cin-only R2");
    apply({64{1'b1}}, 64'h0, 1'b1, "full-propagate R3");
    apply({64{1'b1}}, {64{1'b1}}, 1'b1, "all-ones R3");
    apply({64{1'b1}}, {64{1'b1}}, 1'b0, "all-ones-nocin R7");
    apply({16{4'h8}}, {16{4'h8}}, 1'b0, "top-bit-generate R3");
    apply({16{4'h7}}, {16{4'h1}}, 1'b0, "low-generate R3");
    apply({16{4'hA}}, {16{4'h5}}, 1'b1, "alternating R4");
    apply(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, "select-chain R4");
    apply(64'hFFFF_0000_0000_0000, 64'h0000_FFFF_FFFF_FFFF, 1'b1, "upper-select R5");
    apply(64'h0F0F_0F0F_0F0F_0F0F, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, "slice-max R5");

    for (int k = 0; k < 2000; k++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (k % 4 == 1) y = ~x;
      apply(x, y, 1'($urandom), "random R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule